// File: doc/BRIEF.md
# Calendar Clock with Weekday Alarm

This block keeps wall-clock time and a calendar. It is clocked by the system clock and moves forward one second on each cycle where a one-second tick enable is high. Seconds and minutes roll over at 60 and hours at 24. When the day ends, the day of week and the date move forward. The date rolls over after 31, 30 or 28 days, depending on the current month. When the date rolls over, the month moves forward. Leap years are not handled: February always has 28 days.

An alarm compares the current hour and minute with a programmable setting and drives a buzz output. The buzz lasts as long as the match holds and the alarm is enabled. The buzz never sounds on weekday codes 5 and 6, which are the weekend. Two load strobes preset the time of day and the calendar fields. This is how the block is set after power-up.

Top module: `cal_clock`

## Requirements
- R1: After reset the outputs read hour 0, minute 0, second 0, day of week 0, date 1 and month 1, and buzz is low while the alarm does not match.
- R2: On a cycle with tick low and both load strobes low, no time or calendar field changes.
- R3: On each tick the second advances modulo 60. A second wrap advances the minute modulo 60, and a minute wrap advances the hour modulo 24. All these carries take effect on the same clock edge.
- R4: The day of week (0 to 6) advances modulo 7 only on the tick that takes the time from 23:59:59 to 00:00:00.
- R5: The date runs from 1 to N and returns to 1 after the day-end tick on date N. A 2-bit month-type code selects N: code 00 gives 31 (months 1, 3, 5, 7, 8, 10, 12), code 01 gives 30 (months 4, 6, 9, 11), and code 10 gives 28 (month 2).
- R6: The month runs from 1 to 12. It advances on the tick where the date wraps, and it goes from 12 back to 1.
- R7: Buzz is high exactly when the alarm enable is high, hour and minute equal the alarm hour and minute, and the day of week is neither 5 nor 6. Buzz is combinational from the current registered fields.
- R8: A high load_time replaces hour, minute and second with the set values on the next edge. A high load_date replaces day of week, date and month. On any cycle with a load strobe high, the tick is ignored and the fields that are not loaded hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance enable |
| load_time | input | 1 | Preset hour, minute and second |
| load_date | input | 1 | Preset day of week, date and month |
| set_hour | input | 5 | Hour preset value |
| set_min | input | 6 | Minute preset value |
| set_sec | input | 6 | Second preset value |
| set_dow | input | 3 | Day-of-week preset value |
| set_date | input | 5 | Date preset value |
| set_month | input | 4 | Month preset value |
| alm_en | input | 1 | Alarm enable |
| alm_hour | input | 5 | Alarm hour |
| alm_min | input | 6 | Alarm minute |
| hour | output | 5 | Current hour, 0 to 23 |
| min | output | 6 | Current minute, 0 to 59 |
| sec | output | 6 | Current second, 0 to 59 |
| dow | output | 3 | Day of week, 0 to 6 |
| date | output | 5 | Date in month, 1 to N |
| month | output | 4 | Month, 1 to 12 |
| buzz | output | 1 | Alarm output |

## Verification
The assertions check, on every cycle, the following:
- Idle cycles leave every field stable.
- A second at 59 wraps to 0 on a tick.
- The day of week moves only at the day boundary.
- December 31 at day end wraps to January 1.
- Loads land the set values.
- Buzz never sounds on a weekend code or while the alarm is disabled.

The bench covers what a property cannot. A sweep of several thousand ticks across midnight and a month end compares every field with an arithmetic model. A month-by-month sweep hits the last day and the day before it in all twelve months. A sweep over all seven weekdays, with the alarm enabled and disabled, shows that buzz follows the alarm match exactly.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DOW_W  = 3;
    localparam int DATE_W = 5;
    localparam int MON_W  = 4;

    typedef enum logic [1:0] {
        MT_LONG  = 2'b00,
        MT_SHORT = 2'b01,
        MT_FEB   = 2'b10
    } mtype_e;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
        logic [DOW_W-1:0]  dow;
        logic [DATE_W-1:0] date;
        logic [MON_W-1:0]  month;
    } cal_state_t;
endpackage

// File: rtl/cal_step.sv
// Wrapping increment stage: LO..top, with a wrap carry out.
module cal_step #(
    parameter int W  = 6,
    parameter int LO = 0
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] top,
    input  logic         inc,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    always_comb begin
        wrap = inc && (cur == top);
        if (!inc)
            nxt = cur;
        else if (wrap)
            nxt = W'(LO);
        else
            nxt = cur + 1'b1;
    end
endmodule

// File: rtl/cal_month_len.sv
// Classifies a month number into its length class.
module cal_month_len
    import cal_pkg::*;
(
    input  logic [MON_W-1:0] month,
    output mtype_e           mtype
);
    always_comb begin
        case (month)
            MON_W'(2):                                     mtype = MT_FEB;
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11):  mtype = MT_SHORT;
            default:                                       mtype = MT_LONG;
        endcase
    end
endmodule

// File: rtl/cal_alarm.sv
// Alarm match with weekend suppression.
module cal_alarm
    import cal_pkg::*;
#(
    parameter int WKND_A = 5,
    parameter int WKND_B = 6
) (
    input  logic              en,
    input  logic [HOUR_W-1:0] hour,
    input  logic [MIN_W-1:0]  min,
    input  logic [DOW_W-1:0]  dow,
    input  logic [HOUR_W-1:0] alm_hour,
    input  logic [MIN_W-1:0]  alm_min,
    output logic              buzz
);
    logic match;
    logic weekend;

    always_comb begin
        match   = (hour == alm_hour) && (min == alm_min);
        weekend = (dow == DOW_W'(WKND_A)) || (dow == DOW_W'(WKND_B));
        buzz    = en && match && !weekend;
    end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter int SEC_MOD    = 60,
    parameter int MIN_MOD    = 60,
    parameter int HOUR_MOD   = 24,
    parameter int DOW_MOD    = 7,
    parameter int MON_MOD    = 12,
    parameter int LONG_DAYS  = 31,
    parameter int SHORT_DAYS = 30,
    parameter int FEB_DAYS   = 28,
    parameter int WKND_A     = 5,
    parameter int WKND_B     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_time,
    input  logic              load_date,
    input  logic [HOUR_W-1:0] set_hour,
    input  logic [MIN_W-1:0]  set_min,
    input  logic [SEC_W-1:0]  set_sec,
    input  logic [DOW_W-1:0]  set_dow,
    input  logic [DATE_W-1:0] set_date,
    input  logic [MON_W-1:0]  set_month,
    input  logic              alm_en,
    input  logic [HOUR_W-1:0] alm_hour,
    input  logic [MIN_W-1:0]  alm_min,
    output logic [HOUR_W-1:0] hour,
    output logic [MIN_W-1:0]  min,
    output logic [SEC_W-1:0]  sec,
    output logic [DOW_W-1:0]  dow,
    output logic [DATE_W-1:0] date,
    output logic [MON_W-1:0]  month,
    output logic              buzz
);
    localparam logic [SEC_W-1:0]  SEC_TOP  = SEC_W'(SEC_MOD - 1);
    localparam logic [MIN_W-1:0]  MIN_TOP  = MIN_W'(MIN_MOD - 1);
    localparam logic [HOUR_W-1:0] HOUR_TOP = HOUR_W'(HOUR_MOD - 1);
    localparam logic [DOW_W-1:0]  DOW_TOP  = DOW_W'(DOW_MOD - 1);
    localparam logic [MON_W-1:0]  MON_TOP  = MON_W'(MON_MOD);

    cal_state_t st_d, st_q;

    logic [SEC_W-1:0]  sec_n;
    logic [MIN_W-1:0]  min_n;
    logic [HOUR_W-1:0] hour_n;
    logic [DOW_W-1:0]  dow_n;
    logic [DATE_W-1:0] date_n;
    logic [MON_W-1:0]  mon_n;
    logic sec_wrap_d, min_wrap_d, hour_wrap_d, dow_wrap_d, date_wrap_d, mon_wrap_d;
    logic [DATE_W-1:0] date_top_d;
    mtype_e            mtype_d;

    cal_step #(.W(SEC_W), .LO(0)) u_sec (
        .cur(st_q.sec), .top(SEC_TOP), .inc(tick),
        .nxt(sec_n), .wrap(sec_wrap_d));
    cal_step #(.W(MIN_W), .LO(0)) u_min (
        .cur(st_q.min), .top(MIN_TOP), .inc(sec_wrap_d),
        .nxt(min_n), .wrap(min_wrap_d));
    cal_step #(.W(HOUR_W), .LO(0)) u_hour (
        .cur(st_q.hour), .top(HOUR_TOP), .inc(min_wrap_d),
        .nxt(hour_n), .wrap(hour_wrap_d));
    cal_step #(.W(DOW_W), .LO(0)) u_dow (
        .cur(st_q.dow), .top(DOW_TOP), .inc(hour_wrap_d),
        .nxt(dow_n), .wrap(dow_wrap_d));
    cal_step #(.W(DATE_W), .LO(1)) u_date (
        .cur(st_q.date), .top(date_top_d), .inc(hour_wrap_d),
        .nxt(date_n), .wrap(date_wrap_d));
    cal_step #(.W(MON_W), .LO(1)) u_mon (
        .cur(st_q.month), .top(MON_TOP), .inc(date_wrap_d),
        .nxt(mon_n), .wrap(mon_wrap_d));

    cal_month_len u_mlen (
        .month(st_q.month), .mtype(mtype_d));

    // Length of the current month from its class code.
    always_comb begin
        case (mtype_d)
            MT_SHORT: date_top_d = DATE_W'(SHORT_DAYS);
            MT_FEB:   date_top_d = DATE_W'(FEB_DAYS);
            default:  date_top_d = DATE_W'(LONG_DAYS);
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (load_time || load_date) begin
            if (load_time) begin
                st_d.hour = set_hour;
                st_d.min  = set_min;
                st_d.sec  = set_sec;
            end
            if (load_date) begin
                st_d.dow   = set_dow;
                st_d.date  = set_date;
                st_d.month = set_month;
            end
        end else begin
            st_d.sec   = sec_n;
            st_d.min   = min_n;
            st_d.hour  = hour_n;
            st_d.dow   = dow_n;
            st_d.date  = date_n;
            st_d.month = mon_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hour  <= '0;
            st_q.min   <= '0;
            st_q.sec   <= '0;
            st_q.dow   <= '0;
            st_q.date  <= DATE_W'(1);
            st_q.month <= MON_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    cal_alarm #(.WKND_A(WKND_A), .WKND_B(WKND_B)) u_alarm (
        .en(alm_en), .hour(st_q.hour), .min(st_q.min), .dow(st_q.dow),
        .alm_hour(alm_hour), .alm_min(alm_min), .buzz(buzz));

    assign hour  = st_q.hour;
    assign min   = st_q.min;
    assign sec   = st_q.sec;
    assign dow   = st_q.dow;
    assign date  = st_q.date;
    assign month = st_q.month;

    logic unused_wraps;
    assign unused_wraps = dow_wrap_d ^ mon_wrap_d;
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
    import cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              load_time,
    input logic              load_date,
    input logic [HOUR_W-1:0] set_hour,
    input logic [MIN_W-1:0]  set_min,
    input logic [SEC_W-1:0]  set_sec,
    input logic [DOW_W-1:0]  set_dow,
    input logic [DATE_W-1:0] set_date,
    input logic [MON_W-1:0]  set_month,
    input logic              alm_en,
    input logic [HOUR_W-1:0] hour,
    input logic [MIN_W-1:0]  min,
    input logic [SEC_W-1:0]  sec,
    input logic [DOW_W-1:0]  dow,
    input logic [DATE_W-1:0] date,
    input logic [MON_W-1:0]  month,
    input logic              buzz
);
    logic idle, day_end;
    assign idle    = !tick && !load_time && !load_date;
    assign day_end = (hour == 5'd23) && (min == 6'd59) && (sec == 6'd59);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> ($stable(sec) && $stable(min) && $stable(hour) &&
                  $stable(dow) && $stable(date) && $stable(month)));

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_time && !load_date && sec == 6'd59) |=> (sec == 6'd0));

    // R4
    dow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_date && !(tick && day_end)) |=> $stable(dow));

    // R6
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_time && !load_date && day_end && month == 4'd12 && date == 5'd31)
        |=> (month == 4'd1 && date == 5'd1));

    // R8
    load_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_time |=> (sec == $past(set_sec) && min == $past(set_min) && hour == $past(set_hour)));

    // R8
    load_date_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_date |=> (dow == $past(set_dow) && date == $past(set_date) && month == $past(set_month)));

    // R7
    weekend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buzz && (dow == 3'd5 || dow == 3'd6)));

    // R7
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buzz |-> alm_en);
endmodule

bind cal_clock cal_clock_chk u_cal_clock_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_time(load_time), .load_date(load_date),
    .set_hour(set_hour), .set_min(set_min), .set_sec(set_sec), .set_dow(set_dow),
    .set_date(set_date), .set_month(set_month), .alm_en(alm_en),
    .hour(hour), .min(min), .sec(sec), .dow(dow), .date(date), .month(month), .buzz(buzz));

// File: tb/tb_cal_clock.sv
`timescale 1ns/1ps
module tb_cal_clock;
    import cal_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, load_time = 1'b0, load_date = 1'b0, alm_en = 1'b0;
    logic [HOUR_W-1:0] set_hour = '0, alm_hour = 5'd12;
    logic [MIN_W-1:0]  set_min = '0, alm_min = 6'd34;
    logic [SEC_W-1:0]  set_sec = '0;
    logic [DOW_W-1:0]  set_dow = '0;
    logic [DATE_W-1:0] set_date = 5'd1;
    logic [MON_W-1:0]  set_month = 4'd1;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
    logic [DOW_W-1:0]  dow;
    logic [DATE_W-1:0] date;
    logic [MON_W-1:0]  month;
    logic              buzz;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cal_clock dut (.*);

    function automatic int mdays(int m);
        if (m == 2) return 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] pack(int h, int mi, int s, int d, int dt, int mo);
        return {3'b0, h[4:0], mi[5:0], s[5:0], d[2:0], dt[4:0], mo[3:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] now();
        return {3'b0, hour, min, sec, dow, date, month};
    endfunction

    // Applies inputs for one cycle; returns after the edge that uses them.
    task automatic cyc(logic t, logic lt, logic ld);
        tick = t; load_time = lt; load_date = ld;
        @(negedge clk);
        tick = 0; load_time = 0; load_date = 0;
    endtask

    task automatic preset(int h, int mi, int s, int d, int dt, int mo);
        set_hour = h[4:0]; set_min = mi[5:0]; set_sec = s[5:0];
        set_dow = d[2:0]; set_date = dt[4:0]; set_month = mo[3:0];
        cyc(0, 1, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state and quiet buzz
        chk("R1 reset fields", now(), pack(0, 0, 0, 0, 1, 1));
        chk("R1 reset buzz", {31'b0, buzz}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R2 idle cycles hold the state
        preset(10, 20, 30, 2, 15, 7);
        for (int i = 0; i < 8; i++) cyc(0, 0, 0);
        chk("R2 idle hold", now(), pack(10, 20, 30, 2, 15, 7));

        // R3 R4 R5 long sweep across midnight and a 31-day month end
        preset(22, 58, 0, 6, 31, 3);
        for (int k = 1; k <= 4000; k++) begin
            int tot, t;
            logic [31:0] e;
            cyc(1, 0, 0);
            tot = 22 * 3600 + 58 * 60 + k;
            if (tot >= 86400) begin
                t = tot - 86400;
                e = pack(t / 3600, (t / 60) % 60, t % 60, 0, 1, 4);
            end else begin
                t = tot;
                e = pack(t / 3600, (t / 60) % 60, t % 60, 6, 31, 3);
            end
            chk("R3 R4 R5 sweep", now(), e);
        end

        // R5 R6 R4 every month: last day wraps, day before does not
        for (int m = 1; m <= 12; m++) begin
            preset(23, 59, 59, m % 7, mdays(m), m);
            cyc(1, 0, 0);
            chk("R5 R6 month end", now(), pack(0, 0, 0, (m + 1) % 7, 1, (m % 12) + 1));
            preset(23, 59, 59, m % 7, mdays(m) - 1, m);
            cyc(1, 0, 0);
            chk("R5 day before end", now(), pack(0, 0, 0, (m + 1) % 7, mdays(m), m));
        end

        // R4 hour rollover short of day end leaves the weekday alone
        preset(5, 59, 59, 3, 10, 5);
        cyc(1, 0, 0);
        chk("R4 no dow move", now(), pack(6, 0, 0, 3, 10, 5));

        // R8 load beats tick; a load of one group holds the other
        preset(1, 2, 3, 4, 5, 6);
        set_hour = 5'd9; set_min = 6'd8; set_sec = 6'd7;
        cyc(1, 1, 0);
        chk("R8 time load with tick", now(), pack(9, 8, 7, 4, 5, 6));
        set_dow = 3'd1; set_date = 5'd20; set_month = 4'd11;
        cyc(1, 0, 1);
        chk("R8 date load with tick", now(), pack(9, 8, 7, 1, 20, 11));

        // R7 alarm across all weekdays, enabled and disabled
        alm_hour = 5'd7; alm_min = 6'd30;
        for (int d = 0; d < 7; d++) begin
            for (int en = 0; en < 2; en++) begin
                alm_en = en[0];
                preset(7, 30, 10, d, 9, 9);
                #1;
                chk("R7 match", {31'b0, buzz}, {31'b0, (en == 1) && (d < 5)});
                alm_min = 6'd31; #1;
                chk("R7 minute mismatch", {31'b0, buzz}, 32'd0);
                alm_min = 6'd30; alm_hour = 5'd8; #1;
                chk("R7 hour mismatch", {31'b0, buzz}, 32'd0);
                alm_hour = 5'd7;
            end
        end
        alm_en = 0;

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule